// File: doc/BRIEF.md
# Addressed Frame Receiver with CRC-16 Check

This block sits between a byte deserializer and a receive buffer on a shared serial bus. Each received byte arrives as a one-cycle strobe, and a separate pulse from the bus idle detector marks the gap between frames. A frame has three header bytes: sender address, target address and payload length. The payload follows, and a 16-bit CRC closes the frame. The block counts bytes against the length field. It decides from three address settings whether the frame belongs to this node. It writes kept bytes into the buffer by position and reports the outcome of each frame as a pulse.

The CRC is the reflected 0xA001 polynomial, preset to 0xFFFF. It is computed over the header and payload and sent low byte first. An option hands CRC checking over to software. A second option keeps damaged frames, and in that case the block reports the position of the last byte that arrived. When no buffer is free, the block flags the frame as lost rather than storing it.

Top module: `frame_rx_filter`

## Requirements
- R1: An accepted frame is written one byte per strobe, with `wr_idx` equal to the byte's position, where 0 is the sender byte. Writes cover the header, payload and both CRC bytes. Byte writes from position 2 onward appear one cycle after the byte strobe. The sender byte is written one cycle after the target byte arrives, and the target byte one cycle after that. Input byte strobes are at least three cycles apart.
- R2: A frame ends at the byte at position length+4, so it holds 3 + length + 2 bytes in total. If the CRC is good, `frame_good` pulses one cycle after that byte. Any further bytes are ignored until the next `bus_idle` pulse. The lengths 0 and 253 are valid.
- R3: The filter rules apply in this order:
  - A local address of 0xFF accepts every frame.
  - Otherwise, a sender equal to the local address causes a drop.
  - A target of 0xFF is accepted.
  - A target equal to a multicast setting is accepted, provided that setting is not 0xFF.
  - A target equal to the local address is accepted.
  - Every other frame is dropped.
- R4: If the CRC over the whole frame does not check, the frame is broken. In that case `frame_broken` pulses, and `frame_good` does not.
- R5: A `bus_idle` pulse that arrives after the target byte, but before the frame has ended, makes the frame broken. `frame_broken` then pulses one cycle after the idle pulse.
- R6: `broken_idx` is updated with `frame_broken`. If `keep_broken` is high, it holds the position of the last byte received. If `keep_broken` is low, it is 0. A good frame also sets it to 0.
- R7: A length byte above 253 makes the frame broken at position 2. That byte is not written, and the rest of the frame is ignored.
- R8: `buf_free` is sampled when the target byte arrives. If it is low, the frame produces no writes. A good ending then pulses `frame_lost` instead of `frame_good`. A broken ending with `keep_broken` high pulses `frame_lost` together with `frame_broken`.
- R9: When `user_crc` is high, the CRC is not checked. A frame of full length ends as good.
- R10: A frame dropped by the filter produces no writes and no status pulses.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| bus_idle | input | 1 | Bus idle pulse, marks a frame boundary |
| local_addr | input | 8 | Node address; 0xFF selects accept-all |
| mcast_a | input | 8 | First multicast address, 0xFF disables it |
| mcast_b | input | 8 | Second multicast address, 0xFF disables it |
| keep_broken | input | 1 | Keep broken frames and report their end position |
| user_crc | input | 1 | Skip the CRC check |
| buf_free | input | 1 | A receive buffer is available |
| wr_en | output | 1 | Buffer write strobe |
| wr_idx | output | IW | Byte position within the frame |
| wr_data | output | 8 | Byte to write |
| frame_good | output | 1 | Good frame stored |
| frame_broken | output | 1 | Broken frame |
| frame_lost | output | 1 | Frame kept, but no buffer was free |
| broken_idx | output | IW | Last byte position of a kept broken frame |

## Verification
The bench builds the block with the default MAX_LEN of 253. With that value the longest legal frame, 258 bytes, can be sent within the run. This exercises the full 9-bit position range and the boundary between length 253 and the rejected length 254. A table of address-setting and header combinations exercises each filter rule, including loopback taking priority over broadcast. Directed frames then cover a corrupted CRC, idle-cut frames with and without `keep_broken`, a missing buffer, a software-handled CRC, trailing bytes after the end, and a zero-length payload.

// File: rtl/frame_rx_filter.sv
module frame_rx_filter #(
  parameter int MAX_LEN = 253,
  parameter logic [15:0] CRC_POLY = 16'hA001,
  localparam int IW = $clog2(MAX_LEN + 6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          bus_idle,
  input  logic [7:0]    local_addr,
  input  logic [7:0]    mcast_a,
  input  logic [7:0]    mcast_b,
  input  logic          keep_broken,
  input  logic          user_crc,
  input  logic          buf_free,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          frame_good,
  output logic          frame_broken,
  output logic          frame_lost,
  output logic [IW-1:0] broken_idx
);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic [IW-1:0] cnt;
  logic          skip, has_buf, pend_dst;
  logic [7:0]    src_q, dst_q, len_q;
  logic [15:0]   crc;

  wire [15:0]   crc_nx   = crc_step((cnt == '0) ? 16'hFFFF : crc, byte_data);
  wire          hit_a    = (mcast_a != 8'hFF) && (byte_data == mcast_a);
  wire          hit_b    = (mcast_b != 8'hFF) && (byte_data == mcast_b);
  wire          accept   = (local_addr == 8'hFF) ||
                           ((src_q != local_addr) &&
                            ((byte_data == 8'hFF) || hit_a || hit_b || (byte_data == local_addr)));
  wire [IW-1:0] last_idx = IW'(len_q) + IW'(4);
  wire          in_frame = !skip && (cnt >= IW'(2));
  wire          len_bad  = int'(byte_data) > MAX_LEN;
  wire          crc_ok   = user_crc || (crc_nx == 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; skip <= 1'b0; has_buf <= 1'b0; pend_dst <= 1'b0;
      src_q <= '0; dst_q <= '0; len_q <= '0; crc <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      frame_good <= 1'b0; frame_broken <= 1'b0; frame_lost <= 1'b0; broken_idx <= '0;
    end else begin
      wr_en <= 1'b0;
      frame_good <= 1'b0;
      frame_broken <= 1'b0;
      frame_lost <= 1'b0;
      if (pend_dst) begin
        wr_en <= 1'b1;
        wr_idx <= IW'(1);
        wr_data <= dst_q;
        pend_dst <= 1'b0;
      end
      if (bus_idle) begin
        if (in_frame) begin
          frame_broken <= 1'b1;
          broken_idx <= keep_broken ? (cnt - IW'(1)) : '0;
          frame_lost <= keep_broken && !has_buf;
        end
        cnt <= '0;
        skip <= 1'b0;
      end else if (byte_vld && !skip) begin
        cnt <= cnt + IW'(1);
        crc <= crc_nx;
        if (cnt == '0) begin
          src_q <= byte_data;
        end else if (cnt == IW'(1)) begin
          dst_q <= byte_data;
          if (!accept) begin
            skip <= 1'b1;
          end else begin
            has_buf <= buf_free;
            if (buf_free) begin
              wr_en <= 1'b1;
              wr_idx <= '0;
              wr_data <= src_q;
              pend_dst <= 1'b1;
            end
          end
        end else if (cnt == IW'(2) && len_bad) begin
          skip <= 1'b1;
          frame_broken <= 1'b1;
          broken_idx <= keep_broken ? IW'(2) : '0;
          frame_lost <= keep_broken && !has_buf;
        end else begin
          if (cnt == IW'(2)) len_q <= byte_data;
          if (has_buf) begin
            wr_en <= 1'b1;
            wr_idx <= cnt;
            wr_data <= byte_data;
          end
          if (cnt >= IW'(3) && cnt == last_idx) begin
            skip <= 1'b1;
            if (crc_ok) begin
              frame_good <= has_buf;
              frame_lost <= !has_buf;
              broken_idx <= '0;
            end else begin
              frame_broken <= 1'b1;
              broken_idx <= keep_broken ? cnt : '0;
              frame_lost <= keep_broken && !has_buf;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/frame_rx_filter_chk.sv
module frame_rx_filter_chk #(
  parameter int MAX_LEN = 253,
  localparam int IW = $clog2(MAX_LEN + 6)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic          bus_idle,
  input logic          keep_broken,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          frame_good,
  input logic          frame_broken,
  input logic          frame_lost,
  input logic [IW-1:0] broken_idx
);

  assert_idx_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= IW'(MAX_LEN + 4)));

  assert_good_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> $past(byte_vld));

  assert_good_not_broken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> !frame_broken);

  assert_broken_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_broken |-> ($past(bus_idle) || $past(byte_vld)));

  assert_idx_zero_unkept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_broken && !$past(keep_broken)) |-> (broken_idx == '0));

  assert_lost_not_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |-> !frame_good);

endmodule

bind frame_rx_filter frame_rx_filter_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .bus_idle(bus_idle),
  .keep_broken(keep_broken), .wr_en(wr_en), .wr_idx(wr_idx),
  .frame_good(frame_good), .frame_broken(frame_broken), .frame_lost(frame_lost),
  .broken_idx(broken_idx)
);

// File: tb/test_frame_rx_filter.sv
module test_frame_rx_filter;
  localparam int IW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_vld = 1'b0, bus_idle = 1'b0;
  logic [7:0] byte_data = '0, local_addr = 8'h10, mcast_a = 8'hFF, mcast_b = 8'hFF;
  logic keep_broken = 1'b0, user_crc = 1'b0, buf_free = 1'b1;
  logic wr_en, frame_good, frame_broken, frame_lost;
  logic [IW-1:0] wr_idx, broken_idx;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  frame_rx_filter i_frame_rx_filter (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data), .bus_idle(bus_idle),
    .local_addr(local_addr), .mcast_a(mcast_a), .mcast_b(mcast_b),
    .keep_broken(keep_broken), .user_crc(user_crc), .buf_free(buf_free),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .frame_good(frame_good), .frame_broken(frame_broken), .frame_lost(frame_lost),
    .broken_idx(broken_idx)
  );

  int errors = 0, checks = 0;
  int nwr, ngood, nbrk, nlost, bidx;
  logic [7:0] fr [0:263];
  logic [7:0] wmem [0:263];

  always @(negedge clk) begin
    if (wr_en) begin wmem[wr_idx] = wr_data; nwr++; end
    if (frame_good) ngood++;
    if (frame_broken) begin nbrk++; bidx = int'(broken_idx); end
    if (frame_lost) nlost++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic send_frame(input logic [7:0] src, input logic [7:0] dst, input int len,
                            input bit bad, input int cut, input int extra);
    int total, n;
    logic [15:0] c;
    nwr = 0; ngood = 0; nbrk = 0; nlost = 0; bidx = -1;
    fr[0] = src; fr[1] = dst; fr[2] = 8'(len);
    for (int i = 0; i < len && i < 256; i++) fr[3 + i] = 8'(8'h5A + i * 7);
    c = crc16(len + 3);
    fr[len + 3] = c[7:0];
    fr[len + 4] = c[15:8] ^ (bad ? 8'h01 : 8'h00);
    total = len + 5;
    n = (cut > 0) ? cut : total;
    for (int i = 0; i < n + extra; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = (i < n) ? fr[i] : 8'hC3;
      @(negedge clk); byte_vld = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); bus_idle = 1'b1;
    @(negedge clk); bus_idle = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // {local, mcast_a, mcast_b, src, dst, expect_accept}
  localparam logic [47:0] VEC [8] = '{
    {8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34, 8'd1},
    {8'h10, 8'hFF, 8'hFF, 8'h10, 8'hFF, 8'd0},
    {8'h10, 8'hFF, 8'hFF, 8'h22, 8'hFF, 8'd1},
    {8'h10, 8'hE0, 8'hE1, 8'h22, 8'hE1, 8'd1},
    {8'h10, 8'hE0, 8'hE1, 8'h22, 8'hE0, 8'd1},
    {8'h10, 8'hFF, 8'hFF, 8'h22, 8'h10, 8'd1},
    {8'h10, 8'hE0, 8'hFF, 8'h22, 8'h33, 8'd0},
    {8'h10, 8'hFF, 8'hFF, 8'h10, 8'h10, 8'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 outputs after reset", int'({wr_en, frame_good, frame_broken, frame_lost}) + int'(broken_idx) + int'(wr_idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      local_addr = VEC[v][47:40]; mcast_a = VEC[v][39:32]; mcast_b = VEC[v][31:24];
      send_frame(VEC[v][23:16], VEC[v][15:8], 1, 1'b0, 0, 0);
      chk($sformatf("R3 filter vector %0d good", v), ngood, int'(VEC[v][7:0]));
      chk($sformatf("R10 filter vector %0d writes", v), nwr, VEC[v][0] ? 6 : 0);
      if (VEC[v][0] == 1'b0) chk($sformatf("R10 vector %0d pulses", v), nbrk + nlost, 0);
    end

    local_addr = 8'h10; mcast_a = 8'hFF; mcast_b = 8'hFF;
    send_frame(8'h22, 8'h10, 3, 1'b0, 0, 0);
    chk("R1 write count", nwr, 8);
    begin
      int mism = 0;
      for (int i = 0; i < 8; i++) if (wmem[i] !== fr[i]) mism++;
      chk("R1 written bytes by position", mism, 0);
    end

    send_frame(8'h22, 8'h10, 2, 1'b0, 0, 2);
    chk("R2 trailing bytes good", ngood, 1);
    chk("R2 trailing bytes not written", nwr, 7);
    chk("R2 trailing no broken", nbrk, 0);

    send_frame(8'h22, 8'h10, 0, 1'b0, 0, 0);
    chk("R2 zero length good", ngood, 1);

    send_frame(8'h22, 8'h10, 253, 1'b0, 0, 0);
    chk("R2 max length good", ngood, 1);
    chk("R2 max length writes", nwr, 258);

    keep_broken = 1'b1;
    send_frame(8'h22, 8'h10, 4, 1'b1, 0, 0);
    chk("R4 bad crc broken", nbrk, 1);
    chk("R4 bad crc no good", ngood, 0);
    chk("R6 bad crc index", bidx, 8);

    send_frame(8'h22, 8'h10, 6, 1'b0, 5, 0);
    chk("R5 idle cut broken", nbrk, 1);
    chk("R6 idle cut index", bidx, 4);

    keep_broken = 1'b0;
    send_frame(8'h22, 8'h10, 6, 1'b0, 5, 0);
    chk("R6 unkept index zero", bidx, 0);
    keep_broken = 1'b1;

    send_frame(8'h22, 8'h10, 254, 1'b0, 3, 0);
    chk("R7 long length broken", nbrk, 1);
    chk("R7 long length index", bidx, 2);
    chk("R7 long length writes", nwr, 2);

    buf_free = 1'b0;
    send_frame(8'h22, 8'h10, 2, 1'b0, 0, 0);
    chk("R8 no buffer lost", nlost, 1);
    chk("R8 no buffer no good", ngood, 0);
    chk("R8 no buffer no writes", nwr, 0);
    send_frame(8'h22, 8'h10, 2, 1'b0, 4, 0);
    chk("R8 broken kept lost", nlost + nbrk, 2);
    buf_free = 1'b1;

    user_crc = 1'b1;
    send_frame(8'h22, 8'h10, 3, 1'b1, 0, 0);
    chk("R9 user crc good", ngood, 1);
    user_crc = 1'b0;

    send_frame(8'h22, 8'h44, 3, 1'b1, 4, 0);
    chk("R10 dropped cut frame silent", ngood + nbrk + nlost + nwr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule